// File: doc/BRIEF.md
# Path Remote Defect Indication Code Generator

This block computes the three-bit remote defect indication carried in bits 3:1 of the outgoing path status byte. It updates once per frame, on a frame strobe. Its inputs are five per-frame path defect flags, a mask that suppresses individual defects, a mode select and a software override. The mode select chooses between a legacy coding and an enhanced coding. The legacy coding stays readable by far-end equipment that only understands a single RDI bit. The enhanced coding tells server, connectivity and payload failures apart.

When the hardware raises an indication, the indication stays on for a minimum number of frames (`HOLD_FRAMES`, 20 by default). This holds even when the cause clears sooner. A more severe defect takes over at once and starts a fresh hold. A less severe one waits until the running hold has finished. Software can replace the generated code with a value of its own. While it does so, the hardware hold tracking keeps running underneath.

Top module: `path_rdi_gen`

## Requirements
- R1: When `sw_ovr_en` is 1 at a frame strobe, `rdi_code` equals the `sw_ovr_code` value sampled at that strobe, from the cycle after the strobe until the next strobe.
- R2: A defect whose `defect_inh` bit is 1 has no effect on the generated code. The bit positions in `defect_in` and `defect_inh` are: 0 AIS-P, 1 LOP-P, 2 TIM-P, 3 PLM-P, 4 UNEQ-P.
- R3: In legacy mode (`enh_mode`=0), the generated code is 100 when an unmasked AIS-P or LOP-P is present, and 000 otherwise. TIM-P, PLM-P and UNEQ-P are ignored in this mode.
- R4: In enhanced mode (`enh_mode`=1), the codes are as follows: 101 for a server defect (AIS-P or LOP-P), 110 for a connectivity defect (TIM-P or UNEQ-P), 010 for a payload defect (PLM-P), and 001 when no defect is present.
- R5: When several defect classes are present at once in enhanced mode, server beats connectivity, and connectivity beats payload.
- R6: A hardware-raised code stays on the output for `HOLD_FRAMES` frames after the last frame in which its cause was present. It is then replaced at the next strobe.
- R7: A higher-ranked defect replaces a held lower-ranked code at the same strobe and restarts the hold. A lower-ranked defect is taken only at the strobe after the running hold has expired, and it then gets a hold of its own.
- R8: `rdi_code` changes only in the cycle after a frame strobe or a reset. Changes of `enh_mode` or `sw_ovr_en` between strobes do not show until the next strobe.
- R9: A synchronous active-high reset clears the hold and the override. After reset, `rdi_code` is 001 if `enh_mode` was 1 during reset, and 000 if it was 0.
- R10: When `enh_mode` at a strobe differs from the mode in use, the held code is discarded. The code is then formed from the defects present at that strobe, in the new mode.
- R11: Hold tracking continues while the override is on. If the override is released before the hold expires, the held code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse marking a frame boundary |
| defect_in | input | 5 | Defect flags: 0 AIS-P, 1 LOP-P, 2 TIM-P, 3 PLM-P, 4 UNEQ-P |
| defect_inh | input | 5 | Per-defect inhibit, same bit order |
| enh_mode | input | 1 | 1 selects enhanced coding, 0 selects legacy coding |
| sw_ovr_en | input | 1 | Software override enable |
| sw_ovr_code | input | 3 | Software override value |
| rdi_code | output | 3 | Code for bits 3:1 of the path status byte |

## Verification
The hardest case to reach is a hold interacting with a defect of a different rank. Examples are a server defect arriving during a payload hold, or a connectivity defect that persists through a server hold. Either case only shows its effect about twenty strobes later, at the exact frame where the hold expires. The stimulus resets, raises one defect class, and then drives a long run of strobes carrying the second class. It checks the code at every strobe, so an off-by-one in the reload, or a missing restart, appears at the frame where it happens. Override release during a running hold is reached the same way, with a few overridden frames placed inside the hold window.

// File: rtl/rdi_pkg.sv
package rdi_pkg;

  localparam int NUM_DEFECTS = 5;
  localparam int DF_AIS  = 0;
  localparam int DF_LOP  = 1;
  localparam int DF_TIM  = 2;
  localparam int DF_PLM  = 3;
  localparam int DF_UNEQ = 4;

  typedef enum logic [1:0] {
    RANK_NONE    = 2'd0,
    RANK_PAYLOAD = 2'd1,
    RANK_CONN    = 2'd2,
    RANK_SERVER  = 2'd3
  } rdi_rank_e;

  // Class of the worst unmasked defect for the selected coding
  function automatic rdi_rank_e rank_of(input logic [NUM_DEFECTS-1:0] eff, input logic enh);
    rdi_rank_e r;
    r = RANK_NONE;
    if (eff[DF_AIS] || eff[DF_LOP])
      r = RANK_SERVER;
    else if (enh && (eff[DF_TIM] || eff[DF_UNEQ]))
      r = RANK_CONN;
    else if (enh && eff[DF_PLM])
      r = RANK_PAYLOAD;
    return r;
  endfunction

  // Three-bit field value for a class in a coding
  function automatic logic [2:0] code_of(input rdi_rank_e r, input logic enh);
    logic [2:0] c;
    if (!enh) begin
      c = (r == RANK_SERVER) ? 3'b100 : 3'b000;
    end else begin
      unique case (r)
        RANK_SERVER:  c = 3'b101;
        RANK_CONN:    c = 3'b110;
        RANK_PAYLOAD: c = 3'b010;
        default:      c = 3'b001;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/rdi_defect_classify.sv
module rdi_defect_classify
  import rdi_pkg::*;
(
  input  logic [NUM_DEFECTS-1:0] defect_in,
  input  logic [NUM_DEFECTS-1:0] defect_inh,
  input  logic                   enh_mode,
  output logic [NUM_DEFECTS-1:0] defect_eff,
  output rdi_rank_e              new_rank
);

  for (genvar g = 0; g < NUM_DEFECTS; g++) begin : g_mask
    assign defect_eff[g] = defect_in[g] & ~defect_inh[g];
  end

  assign new_rank = rank_of(defect_eff, enh_mode);

endmodule

// File: rtl/rdi_hold_ctrl.sv
module rdi_hold_ctrl
  import rdi_pkg::*;
#(
  parameter int HOLD_FRAMES = 20,
  localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             enh_mode,
  input  rdi_rank_e        new_rank,
  output rdi_rank_e        held_rank,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             hold_reload,
  output logic             mode_change,
  output logic             mode_q
);

  localparam logic [CNT_W-1:0] RELOAD_VAL = CNT_W'(HOLD_FRAMES - 1);

  logic new_present;
  logic new_outranks;
  logic hold_done;

  assign mode_change  = enh_mode != mode_q;
  assign new_present  = new_rank != RANK_NONE;
  assign new_outranks = new_present && (logic'(2'(new_rank) >= 2'(held_rank)));
  assign hold_done    = hold_cnt == '0;
  assign hold_reload  = mode_change || new_outranks || hold_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_rank <= RANK_NONE;
      hold_cnt  <= '0;
      mode_q    <= enh_mode;
    end else if (frame_stb) begin
      mode_q <= enh_mode;
      if (hold_reload) begin
        held_rank <= new_rank;
        hold_cnt  <= new_present ? RELOAD_VAL : '0;
      end else begin
        hold_cnt  <= hold_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/rdi_out_sel.sv
module rdi_out_sel
  import rdi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_stb,
  input  logic      sw_ovr_en,
  input  logic [2:0] sw_ovr_code,
  input  rdi_rank_e held_rank,
  input  logic      mode_q,
  output logic [2:0] hw_code,
  output logic [2:0] rdi_code
);

  logic       ovr_q;
  logic [2:0] ovr_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q     <= 1'b0;
      ovr_val_q <= 3'b000;
    end else if (frame_stb) begin
      ovr_q     <= sw_ovr_en;
      ovr_val_q <= sw_ovr_code;
    end
  end

  assign hw_code  = code_of(held_rank, mode_q);
  assign rdi_code = ovr_q ? ovr_val_q : hw_code;

endmodule

// File: rtl/path_rdi_gen.sv
module path_rdi_gen
  import rdi_pkg::*;
#(
  parameter int HOLD_FRAMES = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic [4:0] defect_in,
  input  logic [4:0] defect_inh,
  input  logic       enh_mode,
  input  logic       sw_ovr_en,
  input  logic [2:0] sw_ovr_code,
  output logic [2:0] rdi_code
);

  localparam int CNT_W = $clog2(HOLD_FRAMES + 1);

  logic [NUM_DEFECTS-1:0] defect_eff;
  rdi_rank_e              new_rank;
  rdi_rank_e              held_rank;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   hold_reload;
  logic                   mode_change;
  logic                   mode_q;
  logic [2:0]             hw_code;

  rdi_defect_classify u_classify (
    .defect_in  (defect_in),
    .defect_inh (defect_inh),
    .enh_mode   (enh_mode),
    .defect_eff (defect_eff),
    .new_rank   (new_rank)
  );

  rdi_hold_ctrl #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .enh_mode    (enh_mode),
    .new_rank    (new_rank),
    .held_rank   (held_rank),
    .hold_cnt    (hold_cnt),
    .hold_reload (hold_reload),
    .mode_change (mode_change),
    .mode_q      (mode_q)
  );

  rdi_out_sel u_out (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .sw_ovr_en   (sw_ovr_en),
    .sw_ovr_code (sw_ovr_code),
    .held_rank   (held_rank),
    .mode_q      (mode_q),
    .hw_code     (hw_code),
    .rdi_code    (rdi_code)
  );

endmodule

// File: rtl/path_rdi_gen_checker.sv
module path_rdi_gen_checker #(
  parameter int HOLD_FRAMES = 20,
  localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic [4:0]       defect_in,
  input logic [4:0]       defect_inh,
  input logic             enh_mode,
  input logic             sw_ovr_en,
  input logic [2:0]       sw_ovr_code,
  input logic [2:0]       rdi_code,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             hold_reload
);

  logic server_live;
  assign server_live = |(defect_in[1:0] & ~defect_inh[1:0]);

  AST_OVR_PASS: assert property (@(posedge clk) disable iff (rst)
    frame_stb && sw_ovr_en |=> rdi_code == $past(sw_ovr_code)); // R1

  AST_LEGACY_SET: assert property (@(posedge clk) disable iff (rst)
    frame_stb && !sw_ovr_en && !enh_mode |=> (rdi_code == 3'b000 || rdi_code == 3'b100)); // R3

  AST_ENH_SET: assert property (@(posedge clk) disable iff (rst)
    frame_stb && !sw_ovr_en && enh_mode |=>
      (rdi_code == 3'b101 || rdi_code == 3'b110 || rdi_code == 3'b010 || rdi_code == 3'b001)); // R4

  AST_SERVER_WINS: assert property (@(posedge clk) disable iff (rst)
    frame_stb && !sw_ovr_en && enh_mode && server_live |=> rdi_code == 3'b101); // R5

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= CNT_W'(HOLD_FRAMES - 1)); // R6

  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
    frame_stb && !hold_reload |=> hold_cnt == $past(hold_cnt) - 1'b1); // R6

  AST_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(rdi_code)); // R8

endmodule

bind path_rdi_gen path_rdi_gen_checker #(.HOLD_FRAMES(HOLD_FRAMES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_stb   (frame_stb),
  .defect_in   (defect_in),
  .defect_inh  (defect_inh),
  .enh_mode    (enh_mode),
  .sw_ovr_en   (sw_ovr_en),
  .sw_ovr_code (sw_ovr_code),
  .rdi_code    (rdi_code),
  .hold_cnt    (hold_cnt),
  .hold_reload (hold_reload)
);

// File: tb/path_rdi_gen_test.sv
module path_rdi_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [4:0] defect_in = '0;
  logic [4:0] defect_inh = '0;
  logic       enh_mode = 1'b0;
  logic       sw_ovr_en = 1'b0;
  logic [2:0] sw_ovr_code = '0;
  logic [2:0] rdi_code;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  path_rdi_gen #(.HOLD_FRAMES(HOLD)) uut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .defect_in(defect_in),
    .defect_inh(defect_inh), .enh_mode(enh_mode), .sw_ovr_en(sw_ovr_en),
    .sw_ovr_code(sw_ovr_code), .rdi_code(rdi_code)
  );

  // Defect bits: 0 AIS-P, 1 LOP-P, 2 TIM-P, 3 PLM-P, 4 UNEQ-P
  typedef struct packed {
    logic [4:0] d;
    logic [4:0] inh;
    logic       enh;
    logic       ovr;
    logic [2:0] oval;
    logic [2:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{5'b00001, 5'b00000, 1'b0, 1'b0, 3'b000, 3'b100, 4'd3},  // R3 AIS legacy
    '{5'b00010, 5'b00000, 1'b0, 1'b0, 3'b000, 3'b100, 4'd3},  // R3 LOP legacy
    '{5'b11100, 5'b00000, 1'b0, 1'b0, 3'b000, 3'b000, 4'd3},  // R3 others ignored
    '{5'b00001, 5'b00001, 1'b0, 1'b0, 3'b000, 3'b000, 4'd2},  // R2 AIS masked
    '{5'b00001, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b101, 4'd4},  // R4 AIS
    '{5'b00010, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b101, 4'd4},  // R4 LOP
    '{5'b00100, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b110, 4'd4},  // R4 TIM
    '{5'b10000, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b110, 4'd4},  // R4 UNEQ
    '{5'b01000, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b010, 4'd4},  // R4 PLM
    '{5'b00000, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b001, 4'd4},  // R4 none
    '{5'b11111, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b101, 4'd5},  // R5 all
    '{5'b01100, 5'b00000, 1'b1, 1'b0, 3'b000, 3'b110, 4'd5},  // R5 TIM over PLM
    '{5'b11111, 5'b00011, 1'b1, 1'b0, 3'b000, 3'b110, 4'd2},  // R2 server masked
    '{5'b01000, 5'b01000, 1'b1, 1'b0, 3'b000, 3'b001, 4'd2},  // R2 PLM masked
    '{5'b00001, 5'b00000, 1'b1, 1'b1, 3'b011, 3'b011, 4'd1},  // R1 override enh
    '{5'b00000, 5'b00000, 1'b0, 1'b1, 3'b111, 3'b111, 4'd1}   // R1 override legacy
  };

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input int req, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic e);
    @(negedge clk);
    rst = 1'b1; frame_stb = 1'b0; defect_in = '0; defect_inh = '0;
    enh_mode = e; sw_ovr_en = 1'b0; sw_ovr_code = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One strobe, then sample at the following falling edge
  task automatic frame(input logic [4:0] d, input logic [4:0] i, input logic e,
                       input logic o, input logic [2:0] v);
    @(negedge clk);
    defect_in = d; defect_inh = i; enh_mode = e; sw_ovr_en = o; sw_ovr_code = v;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    // Table walk, each vector from a fresh reset
    for (int k = 0; k < NV; k++) begin
      do_reset(VEC[k].enh);
      frame(VEC[k].d, VEC[k].inh, VEC[k].enh, VEC[k].ovr, VEC[k].oval);
      check(rdi_code, VEC[k].exp, int'(VEC[k].req), $sformatf("vector %0d", k));
    end

    // R9 reset values in both modes
    do_reset(1'b0);
    check(rdi_code, 3'b000, 9, "reset legacy");
    do_reset(1'b1);
    check(rdi_code, 3'b001, 9, "reset enhanced");

    // R6 hold after a single-frame server defect
    frame(5'b00001, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b101, 6, "raise");
    for (int f = 1; f < HOLD; f++) begin
      frame('0, '0, 1'b1, 1'b0, '0);
      check(rdi_code, 3'b101, 6, $sformatf("held frame %0d", f));
    end
    frame('0, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b001, 6, "released");

    // R8 mode/override changes between strobes have no effect
    @(negedge clk);
    enh_mode = 1'b0; sw_ovr_en = 1'b1; sw_ovr_code = 3'b110; defect_in = 5'b00001;
    repeat (3) @(negedge clk);
    check(rdi_code, 3'b001, 8, "no strobe, no change");
    frame('0, '0, 1'b0, 1'b0, '0);
    check(rdi_code, 3'b000, 8, "mode applied at strobe");

    // R7 higher rank preempts and restarts hold
    do_reset(1'b1);
    frame(5'b01000, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b010, 7, "payload raised");
    repeat (5) frame('0, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b010, 7, "payload held");
    frame(5'b00010, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b101, 7, "server preempts");
    for (int f = 1; f < HOLD; f++) begin
      frame('0, '0, 1'b1, 1'b0, '0);
      check(rdi_code, 3'b101, 7, $sformatf("restarted hold %0d", f));
    end
    frame('0, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b001, 7, "restarted hold ends");

    // R7 lower rank waits for hold expiry
    do_reset(1'b1);
    frame(5'b00001, '0, 1'b1, 1'b0, '0);
    for (int f = 1; f < HOLD; f++) begin
      frame(5'b00100, '0, 1'b1, 1'b0, '0);
      check(rdi_code, 3'b101, 7, $sformatf("lower waits %0d", f));
    end
    frame(5'b00100, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b110, 7, "lower taken");

    // R10 mode change discards hold
    do_reset(1'b1);
    frame(5'b00001, '0, 1'b1, 1'b0, '0);
    frame('0, '0, 1'b0, 1'b0, '0);
    check(rdi_code, 3'b000, 10, "hold dropped on mode change");

    // R11 hold runs underneath override
    do_reset(1'b1);
    frame(5'b00001, '0, 1'b1, 1'b0, '0);
    repeat (3) frame('0, '0, 1'b1, 1'b1, 3'b000);
    check(rdi_code, 3'b000, 11, "override active");
    frame('0, '0, 1'b1, 1'b0, '0);
    check(rdi_code, 3'b101, 11, "held code after release");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule